// File: doc/BRIEF.md
# Nested Software-Priority Interrupt Controller

This block decides which of fourteen maskable interrupt sources, or a non-maskable trap, the processor should take next. Every source has a two-bit software priority field kept in a small bank of byte-wide registers. The processor's running priority level is a two-bit code held inside the block. A request is offered to the core only when its level is above the running level. When the core takes the offered interrupt, the running level is raised to the level of that source. The previous level is saved on an internal stack, so that a return from interrupt restores it and nested handlers unwind in order.

The two-bit codes do not rank in numeric order. Code 10 is the main-program level, which is the lowest. Code 01 is level one, code 00 is level two, and code 11 is level three, the highest. Level three masks every maskable source. A software write that would put a source at the main-program level is dropped for that field only. A dedicated port lets software load the running level directly, which covers the clear-mask and set-mask operations. Raising the priority of a source that is in service and still requesting lets it preempt its own handler.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset every priority field holds 11, so each register reads FFh. The running level is 11. No maskable request is granted, even with all request lines high.
- R2: Codes rank as 10 = level 0, 01 = level 1, 00 = level 2 and 11 = level 3. A maskable request is granted only when the level of its field is strictly above the running level. A request at an equal or lower level is not granted.
- R3: Register a, bits [2k+1:2k], hold the field of source 4a+k. Register 3 holds sources 12 and 13 in bits 3:0. Its bits 7:4 always read as ones and ignore writes.
- R4: Within a write, any field written as 10 keeps its old value, and every other field takes the written value. For example, a register at CFh written with 64h then reads 44h.
- R5: Among the eligible maskable requests, the one with the highest level wins. Between equal levels, the lowest source index wins. `grant_vec` gives the index of the winner.
- R6: When `enter` is high while a maskable grant is offered, the running level takes the winning source's field on the next cycle, and the previous level is pushed onto the stack.
- R7: `trap_req` is granted at any running level, including 11, and ahead of every maskable request. It is offered with `grant_trap` = 1 and `grant_vec` = 0. Entering it sets the running level to 11.
- R8: `ret` pops the stack and restores the saved level. Nesting holds up to the stack depth (4 by default). A pop from an empty stack gives 11.
- R9: `lvl_wr` loads `lvl_wdata` into the running level on the next cycle. Writing 10 unmasks all sources, and writing 11 masks them.
- R10: If the field of a source in service is rewritten to a level above the running level while its request is still high, that source is offered again at once. A rewrite to a level that is not higher produces no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Priority register select, used for both read and write |
| reg_wr | input | 1 | Write strobe for the selected priority register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Contents of the selected register (combinational) |
| irq_req | input | 14 | Maskable request lines, one per source |
| trap_req | input | 1 | Non-maskable trap request |
| lvl_wr | input | 1 | Direct write strobe for the running level |
| lvl_wdata | input | 2 | Code to load into the running level |
| enter | input | 1 | Core takes the grant offered in this cycle |
| ret | input | 1 | Return from interrupt; pops the saved level |
| grant_valid | output | 1 | A trap or an eligible request is on offer |
| grant_trap | output | 1 | The offer is the trap |
| grant_vec | output | 4 | Index of the offered maskable source (0 when none is offered or when the trap is offered) |
| cur_lvl | output | 2 | Running priority level code |

## Verification
The hardest case to reach is re-entry of a source that is already in service. The source must first be entered, which raises the running level to its own field. Its request must then stay high while software rewrites only its field. The stimulus does this in order: it enters source 1 at level one, keeps its request line asserted, rewrites register 0 to move that field to level two and checks for a fresh grant, moves the field back and checks that no grant appears, and finally enters the source again. Stack overflow is also covered from the ports. Four nested entries fill the default stack: three maskable sources at rising levels and then a trap. Five returns follow, and the last one must fall back to the masked level.

// File: rtl/nirq_pkg.sv
package nirq_pkg;

   typedef logic [1:0] lvl_code_t;

   localparam lvl_code_t LVL_MAIN = 2'b10;   // lowest, never stored in a field
   localparam lvl_code_t LVL_MASK = 2'b11;   // highest, masks maskable sources

   // Map the two-bit code onto a monotonic rank 0..3:
   // 10->0, 01->1, 00->2, 11->3
   function automatic logic [1:0] lvl_rank(lvl_code_t code);
      return {~(code[1] ^ code[0]), code[0]};
   endfunction

endpackage

// File: rtl/nirq_prio_regs.sv
module nirq_prio_regs
   import nirq_pkg::*;
#(
   parameter int NUM_VEC  = 14,
   parameter int REG_W    = 8,
   parameter int NUM_REGS = 4,
   parameter int ADDR_W   = 2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 wr,
   input  logic [REG_W-1:0]     wdata,
   output logic [REG_W-1:0]     rdata,
   output logic [2*NUM_VEC-1:0] prio_flat
);

   localparam int FPR = REG_W / 2;
   localparam int PAD = FPR * NUM_REGS - NUM_VEC;

   for (genvar v = 0; v < NUM_VEC; v++) begin : g_field
      localparam int RI = v / FPR;
      localparam int KI = v % FPR;

      lvl_code_t field_q;
      logic      hit;
      lvl_code_t wfield;

      assign hit    = wr && (addr == ADDR_W'(RI));
      assign wfield = wdata[2*KI +: 2];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            field_q <= LVL_MASK;
         else if (hit && (wfield != LVL_MAIN))
            field_q <= wfield;
      end

      assign prio_flat[2*v +: 2] = field_q;

      AST_MAIN_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && wfield == LVL_MAIN) |=> (field_q == $past(field_q))); // R4
   end

   always_comb begin
      rdata = '1;
      for (int k = 0; k < FPR; k++) begin
         int v;
         v = int'(addr) * FPR + k;
         if (v < NUM_VEC)
            rdata[2*k +: 2] = prio_flat[2*v +: 2];
      end
   end

   if (PAD > 0) begin : g_pad_chk
      AST_PAD_READS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
         (addr == ADDR_W'(NUM_REGS - 1)) |-> (rdata[REG_W-1 -: 2*PAD] == '1)); // R3
   end

endmodule

// File: rtl/nirq_arbiter.sv
module nirq_arbiter
   import nirq_pkg::*;
#(
   parameter int NUM_VEC = 14,
   parameter int VEC_W   = 4
)(
   input  logic [2*NUM_VEC-1:0] prio_flat,
   input  logic [NUM_VEC-1:0]   req,
   input  logic                 trap_req,
   input  lvl_code_t            cur_lvl,
   output logic                 grant_valid,
   output logic                 grant_trap,
   output logic [VEC_W-1:0]     grant_vec,
   output lvl_code_t            grant_code
);

   logic        found;
   logic [1:0]  best_rank;
   logic [1:0]  cur_rank;
   int          best_idx;
   lvl_code_t   best_code;

   always_comb begin
      cur_rank  = lvl_rank(cur_lvl);
      found     = 1'b0;
      best_rank = '0;
      best_idx  = 0;
      best_code = LVL_MASK;
      // ascending scan with strict compare keeps the lowest index on ties
      for (int v = 0; v < NUM_VEC; v++) begin
         lvl_code_t c;
         logic [1:0] r;
         c = prio_flat[2*v +: 2];
         r = lvl_rank(c);
         if (req[v] && (r > cur_rank) && (!found || r > best_rank)) begin
            found     = 1'b1;
            best_rank = r;
            best_idx  = v;
            best_code = c;
         end
      end
   end

   always_comb begin
      if (trap_req) begin
         grant_valid = 1'b1;
         grant_trap  = 1'b1;
         grant_vec   = '0;
         grant_code  = LVL_MASK;
      end else begin
         grant_valid = found;
         grant_trap  = 1'b0;
         grant_vec   = found ? VEC_W'(best_idx) : '0;
         grant_code  = best_code;
      end
   end

endmodule

// File: rtl/nirq_level_stack.sv
module nirq_level_stack
   import nirq_pkg::*;
#(
   parameter int DEPTH = 4
)(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      push,
   input  lvl_code_t push_code,
   input  logic      pop,
   input  logic      lvl_wr,
   input  lvl_code_t lvl_wdata,
   output lvl_code_t cur_lvl
);

   lvl_code_t                    cur_q;
   logic [DEPTH-1:0][1:0]        stk_q;   // entry 0 is the top

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= LVL_MASK;
         stk_q <= '1;
      end else if (push) begin
         cur_q <= push_code;
         stk_q <= {stk_q[DEPTH-2:0], cur_q};
      end else if (pop) begin
         // the vacated bottom entry refills with the masked level
         cur_q <= stk_q[0];
         stk_q <= {LVL_MASK, stk_q[DEPTH-1:1]};
      end else if (lvl_wr) begin
         cur_q <= lvl_wdata;
      end
   end

   assign cur_lvl = cur_q;

   AST_RET_UNDOES_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(push) && pop && !push) |=> (cur_q == $past(cur_q, 2))); // R8

endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nirq_pkg::*;
#(
   parameter int NUM_VEC     = 14,
   parameter int REG_W       = 8,
   parameter int STACK_DEPTH = 4,
   localparam int FPR        = REG_W / 2,
   localparam int NUM_REGS   = (NUM_VEC + FPR - 1) / FPR,
   localparam int ADDR_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
   localparam int VEC_W      = $clog2(NUM_VEC)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic [NUM_VEC-1:0] irq_req,
   input  logic               trap_req,
   input  logic               lvl_wr,
   input  logic [1:0]         lvl_wdata,
   input  logic               enter,
   input  logic               ret,
   output logic               grant_valid,
   output logic               grant_trap,
   output logic [VEC_W-1:0]   grant_vec,
   output logic [1:0]         cur_lvl
);

   if (REG_W < 2 || (REG_W % 2) != 0) begin : g_bad_regw
      $error("REG_W must be an even width of at least 2");
   end
   if (STACK_DEPTH < 2) begin : g_bad_depth
      $error("STACK_DEPTH must be at least 2");
   end
   if (NUM_VEC < 2) begin : g_bad_nvec
      $error("NUM_VEC must be at least 2");
   end

   logic [2*NUM_VEC-1:0] prio_flat;
   lvl_code_t            grant_code;
   lvl_code_t            cur_code;
   logic                 take;

   nirq_prio_regs #(
      .NUM_VEC(NUM_VEC), .REG_W(REG_W), .NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr),
      .wdata(reg_wdata), .rdata(reg_rdata), .prio_flat(prio_flat)
   );

   nirq_arbiter #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_arb (
      .prio_flat(prio_flat), .req(irq_req), .trap_req(trap_req),
      .cur_lvl(cur_code), .grant_valid(grant_valid), .grant_trap(grant_trap),
      .grant_vec(grant_vec), .grant_code(grant_code)
   );

   assign take = enter && grant_valid;

   nirq_level_stack #(.DEPTH(STACK_DEPTH)) u_lvl (
      .clk(clk), .rst_n(rst_n), .push(take), .push_code(grant_code),
      .pop(ret), .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata), .cur_lvl(cur_code)
   );

   assign cur_lvl = cur_code;

   AST_GRANT_ABOVE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (grant_valid && !grant_trap) |-> (lvl_rank(grant_code) > lvl_rank(cur_code))); // R2

   AST_ENTRY_LOADS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (enter && grant_valid && !grant_trap) |=> (cur_code == $past(grant_code))); // R6

   AST_TRAP_PREEMPTS: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (grant_valid && grant_trap && grant_vec == '0)); // R7

   AST_TRAP_MASKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (enter && grant_trap) |=> (cur_code == LVL_MASK)); // R7

endmodule

// File: tb/tb_nest_irq_ctrl.sv
`timescale 1ns/1ps
module tb_nest_irq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic [13:0] irq_req = '0;
   logic        trap_req = 1'b0;
   logic        lvl_wr = 1'b0;
   logic [1:0]  lvl_wdata = '0;
   logic        enter = 1'b0;
   logic        ret = 1'b0;
   logic        grant_valid;
   logic        grant_trap;
   logic [3:0]  grant_vec;
   logic [1:0]  cur_lvl;

   always #10 clk = ~clk;   // 50 MHz

   nest_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
      .trap_req(trap_req), .lvl_wr(lvl_wr), .lvl_wdata(lvl_wdata),
      .enter(enter), .ret(ret), .grant_valid(grant_valid),
      .grant_trap(grant_trap), .grant_vec(grant_vec), .cur_lvl(cur_lvl)
   );

   // observation selectors
   localparam int OBS_REG   = 0;
   localparam int OBS_LVL   = 1;
   localparam int OBS_GRANT = 2;   // {valid, trap, 2'b00, vec}

   typedef struct {
      string      tag;
      int         sel;
      logic [7:0] exp;
   } sb_item_t;

   sb_item_t sb_q[$];
   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   function automatic logic [7:0] observe(int sel);
      case (sel)
         OBS_REG:   return reg_rdata;
         OBS_LVL:   return {6'b0, cur_lvl};
         default:   return {grant_valid, grant_trap, 2'b00, grant_vec};
      endcase
   endfunction

   // monitor: pops expectations and compares against the ports
   initial begin : monitor
      forever begin
         sb_item_t it;
         logic [7:0] got;
         wait (sb_q.size() != 0);
         #1;
         it  = sb_q.pop_front();
         got = observe(it.sel);
         n_checks++;
         if (got !== it.exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", it.tag, got, it.exp);
         end
      end
   end

   // driver helpers
   task automatic expect_obs(string tag, int sel, logic [7:0] v);
      #1;
      sb_q.push_back('{tag, sel, v});
      wait (sb_q.size() == 0);
      #1;
   endtask

   task automatic wr_reg(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic chk_reg(logic [1:0] a, logic [7:0] e, string tag);
      reg_addr = a;
      expect_obs(tag, OBS_REG, e);
   endtask

   task automatic set_lvl(logic [1:0] v);
      @(negedge clk);
      lvl_wdata = v; lvl_wr = 1'b1;
      @(negedge clk);
      lvl_wr = 1'b0;
   endtask

   task automatic do_enter();
      @(negedge clk);
      enter = 1'b1;
      @(negedge clk);
      enter = 1'b0;
   endtask

   task automatic do_ret();
      @(negedge clk);
      ret = 1'b1;
      @(negedge clk);
      ret = 1'b0;
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
   endtask

   initial begin : watchdog
      #(20 * 50000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin : driver
      irq_req = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 4; a++) chk_reg(2'(a), 8'hFF, "R1 reset reg");
      expect_obs("R1 reset level", OBS_LVL, 8'h03);
      expect_obs("R1 no grant at mask", OBS_GRANT, 8'h00);
      irq_req = '0;

      // R3/R4 register layout and write filtering
      wr_reg(2'd0, 8'hCF);
      chk_reg(2'd0, 8'hCF, "R3 reg0 write");
      wr_reg(2'd0, 8'h64);
      chk_reg(2'd0, 8'h44, "R4 main-level field kept");
      wr_reg(2'd3, 8'h00);
      chk_reg(2'd3, 8'hF0, "R3 reg3 upper ones");
      wr_reg(2'd3, 8'hAA);
      chk_reg(2'd3, 8'hF0, "R4 all fields main ignored");
      chk_reg(2'd1, 8'hFF, "R3 reg1 untouched");

      // R9 direct level write, R2 strict grant rule
      set_lvl(2'b10);
      expect_obs("R9 clear mask", OBS_LVL, 8'h02);
      irq_req = 14'h0002;                           // source 1 at level 1
      expect_obs("R2 level1 over main", OBS_GRANT, 8'h81);
      set_lvl(2'b01);
      expect_obs("R2 equal level no grant", OBS_GRANT, 8'h00);
      set_lvl(2'b00);
      irq_req = 14'h0001;                           // source 0 at level 2
      expect_obs("R2 equal level2 no grant", OBS_GRANT, 8'h00);
      irq_req = 14'h0010;                           // source 4 at level 3
      expect_obs("R2 level3 over level2", OBS_GRANT, 8'h84);

      // R5 arbitration
      set_lvl(2'b10);
      irq_req = 14'h0007;
      expect_obs("R5 tie lowest index", OBS_GRANT, 8'h80);
      irq_req = 14'h2006;
      expect_obs("R5 tie 2 vs 13", OBS_GRANT, 8'h82);
      irq_req = 14'h0026;
      expect_obs("R5 highest level wins", OBS_GRANT, 8'h85);

      // R6 nesting, R7 trap, R8 unwinding
      irq_req = 14'h0002;
      do_enter();
      expect_obs("R6 enter source1", OBS_LVL, 8'h01);
      irq_req = 14'h0001;
      do_enter();
      expect_obs("R6 enter source0", OBS_LVL, 8'h00);
      irq_req = 14'h0020;
      do_enter();
      expect_obs("R6 enter source5", OBS_LVL, 8'h03);
      irq_req = '0;
      trap_req = 1'b1;
      expect_obs("R7 trap offered at mask", OBS_GRANT, 8'hC0);
      irq_req = 14'h0020;
      expect_obs("R7 trap over maskable", OBS_GRANT, 8'hC0);
      irq_req = '0;
      do_enter();
      trap_req = 1'b0;
      expect_obs("R7 trap level", OBS_LVL, 8'h03);
      do_ret();
      expect_obs("R8 pop 1", OBS_LVL, 8'h03);
      do_ret();
      expect_obs("R8 pop 2", OBS_LVL, 8'h00);
      do_ret();
      expect_obs("R8 pop 3", OBS_LVL, 8'h01);
      do_ret();
      expect_obs("R8 pop 4", OBS_LVL, 8'h02);
      do_ret();
      expect_obs("R8 empty pop masks", OBS_LVL, 8'h03);

      // R10 re-entry of an in-service source
      set_lvl(2'b10);
      irq_req = 14'h0002;
      do_enter();
      expect_obs("R10 in service level1", OBS_LVL, 8'h01);
      expect_obs("R10 no self grant", OBS_GRANT, 8'h00);
      wr_reg(2'd0, 8'h40);
      expect_obs("R10 raised re-grant", OBS_GRANT, 8'h81);
      wr_reg(2'd0, 8'h44);
      expect_obs("R10 not higher no grant", OBS_GRANT, 8'h00);
      wr_reg(2'd0, 8'h40);
      do_enter();
      expect_obs("R10 re-entered level2", OBS_LVL, 8'h00);
      irq_req = '0;
      do_ret();
      expect_obs("R8 return from re-entry", OBS_LVL, 8'h01);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule